// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames from a byte stream and places them in a ring of receive descriptors held in shared memory. When a frame starts, it reads the flag word of the current descriptor. The ownership bit tells it whether the controller may use that descriptor. If it may, the block fetches the buffer address and the buffer size, then writes the frame bytes into the buffer one byte at a time. A frame longer than one buffer continues into the next descriptor of the ring. When the frame ends, the block writes the message length into the descriptor, then the status flags with ownership handed back to the host, and pulses a receive event.

If the current descriptor is still held by the host when a frame starts, the frame is discarded and a missed-frame event is pulsed. Address filtering and frame-check validation happen upstream and arrive as inputs. A frame the filter rejects is consumed without any memory access. The stream is stalled (`in_ready` low) while descriptors are fetched or written back.

Each descriptor is four 16-bit words at `ring_base + 4*index`:
- word 0: buffer word address;
- word 1: flag byte in bits 7:0, with bits 15:8 kept unchanged;
- word 2: buffer length, stored negated;
- word 3: received message length.

The memory port has a fixed read latency of one cycle: data read in cycle t is on `mem_rdata` in cycle t+1.

Top module: `rx_ring_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, the block issues no memory read or write, pulses neither event, and holds `in_ready` low when `in_valid` is low.
- R2: At a frame start (`in_first`) with `in_match` high, the block reads flag word 1 of the current descriptor. If bit 7 (OWN, 0x80) is set, byte k of the frame goes to memory word `w0 + k/2`, as a single-lane write. Even k uses bits 7:0 (`mem_be`=01) and odd k uses bits 15:8 (`mem_be`=10).
- R3: The buffer size in bytes is 4096 minus bits 11:0 of word 2. The host stores the negated size there with bits 15:12 set to ones. A frame whose length equals the buffer size uses exactly one descriptor.
- R4: For a frame that fits in one buffer, word 3 receives the byte count including the 4-byte check sequence (bits 11:0, upper bits zero). The flag byte becomes ENP 0x01 | STP 0x02 with OWN cleared, and bits 15:8 of word 1 are preserved.
- R5: When a buffer is full and the frame has more bytes, the block moves to the next descriptor, (index+1) mod ring size. The first descriptor is released with flag byte STP 0x02 only, a middle one with 0x00, and the last one with ENP. Word 3 is written only on the ENP descriptor.
- R6: A frame-check failure flagged on the last byte sets CRC 0x08 and ERR 0x40. A framing error on the last byte sets FRAM 0x20 and ERR 0x40. Both appear only on the ENP descriptor.
- R7: If OWN is clear at frame start, `miss_event` pulses for one cycle. The whole frame is consumed with no memory write, and the same descriptor is tried for the next frame.
- R8: If the next descriptor is host-owned when a chain is needed, the current descriptor is released as final with ENP | OFLO 0x10 | ERR 0x40 (plus STP if it is the first) and word 3 set to the bytes stored. The rest of the frame is discarded and the index advances.
- R9: The ring holds 2^`cfg_ring_order` descriptors, with descriptor i at `cfg_ring_base + 4*i`, and index 0 follows the last one. `cfg_ring_order` is the 3-bit field held in bits 15:13 of the ring-length word.
- R10: For every released ENP descriptor, the length write comes in the cycle just before the flag write that clears OWN. `rx_event` pulses exactly once per stored frame, in the cycle of that flag write.
- R11: A frame that starts with `in_match` low is consumed entirely with no memory access and no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | AW | Word address of descriptor 0 |
| cfg_ring_order | input | ORDER_W | log2 of the ring size |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_match | input | 1 | Address filter verdict, valid with the first byte |
| in_crc_bad | input | 1 | Check-sequence failure, valid with the last byte |
| in_frame_err | input | 1 | Framing error, valid with the last byte |
| in_ready | output | 1 | Byte accepted this cycle when high together with in_valid |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_be | output | 2 | Byte enables for the write |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| rx_event | output | 1 | Frame stored, pulse |
| miss_event | output | 1 | Frame missed, pulse |

## Verification
The bench targets a frame that exactly fills its buffer. A design with an off-by-one in the size decode would chain into a second descriptor or drop the last byte. It drives a three-buffer frame with a check-sequence error, so a design that tags errors on every descriptor, or writes a length into non-final descriptors, leaves wrong flag or length words behind. It also covers a missed frame, a filtered frame, a failed chain that must end in an overflow-marked descriptor, and wrap-around in two ring sizes. In each case a wrong design either writes memory it must not touch, advances the index wrongly (so later frames land in the wrong buffer), or miscounts the event pulses.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    // Flag byte of descriptor word 1
    localparam logic [7:0] FL_ENP  = 8'h01;
    localparam logic [7:0] FL_STP  = 8'h02;
    localparam logic [7:0] FL_CRC  = 8'h08;
    localparam logic [7:0] FL_OFLO = 8'h10;
    localparam logic [7:0] FL_FRAM = 8'h20;
    localparam logic [7:0] FL_ERR  = 8'h40;
    localparam logic [7:0] FL_OWN  = 8'h80;

    // Word offsets inside a descriptor
    localparam logic [1:0] WD_BASE  = 2'd0;
    localparam logic [1:0] WD_FLAGS = 2'd1;
    localparam logic [1:0] WD_BLEN  = 2'd2;
    localparam logic [1:0] WD_MLEN  = 2'd3;

    localparam int BUF_CNT_W = 13;   // up to 4096 bytes per buffer
    localparam int MSG_W     = 12;   // valid bits of the message length

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH_FLAGS, S_CHK_FLAGS, S_FETCH_BASE, S_GOT_BASE,
        S_GOT_LEN, S_DATA, S_CHAIN_FETCH, S_CHAIN_CHK, S_WB_MID,
        S_WB_LEN, S_WB_FLAGS, S_DROP
    } rxr_state_e;

    typedef struct packed {
        logic [15:0]          base;  // buffer word address
        logic [7:0]           hi;    // upper byte of flag word, kept as read
        logic [BUF_CNT_W-1:0] size;  // buffer size in bytes
    } rxr_buf_t;

    // Stored length is negated with bits 15:12 forced to one
    function automatic logic [BUF_CNT_W-1:0] buf_bytes(input logic [11:0] neg_len);
        return BUF_CNT_W'(13'h1000 - {1'b0, neg_len});
    endfunction
endpackage

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
    parameter int ORDER_W = 3,
    parameter int IDX_W   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ORDER_W-1:0] order,
    input  logic               advance,
    output logic [IDX_W-1:0]   cur,
    output logic [IDX_W-1:0]   nxt
);
    logic [IDX_W:0]   span;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] cur_q;

    assign span = (IDX_W + 1)'(1) << order;
    assign mask = IDX_W'(span - (IDX_W + 1)'(1));
    assign cur  = cur_q & mask;
    assign nxt  = (cur + IDX_W'(1)) & mask;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (advance)
            cur_q <= nxt;
    end
endmodule

// File: rtl/rxr_desc_addr.sv
module rxr_desc_addr #(
    parameter int AW    = 16,
    parameter int IDX_W = 7
) (
    input  logic [AW-1:0]    ring_base,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       word,
    output logic [AW-1:0]    addr
);
    assign addr = ring_base + AW'({idx, word});
endmodule

// File: rtl/rxr_byte_lane.sv
module rxr_byte_lane #(
    parameter int AW = 16,
    parameter int CW = 13
) (
    input  logic [15:0]   base,
    input  logic [CW-1:0] offs,
    input  logic [7:0]    data,
    output logic [AW-1:0] addr,
    output logic [1:0]    be,
    output logic [15:0]   wdata
);
    assign addr  = AW'(base) + AW'(offs[CW-1:1]);
    assign be    = offs[0] ? 2'b10 : 2'b01;
    assign wdata = {data, data};
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW      = 16,
    parameter int ORDER_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      cfg_ring_base,
    input  logic [ORDER_W-1:0] cfg_ring_order,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_first,
    input  logic               in_last,
    input  logic               in_match,
    input  logic               in_crc_bad,
    input  logic               in_frame_err,
    output logic               in_ready,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         mem_be,
    output logic [15:0]        mem_wdata,
    input  logic [15:0]        mem_rdata,
    output logic               rx_event,
    output logic               miss_event
);
    localparam int IDX_W = (1 << ORDER_W) - 1;

    rxr_state_e           state_q, state_d;
    rxr_buf_t             buf_q;
    logic [7:0]           nxt_hi_q;
    logic [BUF_CNT_W-1:0] offs_q;
    logic [MSG_W-1:0]     total_q;
    logic                 first_q, crc_q, fram_q, ovf_q;

    logic                 advance, use_nxt, use_lane, byte_take, owned;
    logic [1:0]           word_sel;
    logic [IDX_W-1:0]     cur_idx, nxt_idx;
    logic [AW-1:0]        desc_addr, lane_addr;
    logic [1:0]           lane_be;
    logic [15:0]          lane_data;
    logic [7:0]           fin_flags;

    rxr_ring_index #(.ORDER_W(ORDER_W), .IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst(rst), .order(cfg_ring_order), .advance(advance),
        .cur(cur_idx), .nxt(nxt_idx)
    );

    rxr_desc_addr #(.AW(AW), .IDX_W(IDX_W)) u_daddr (
        .ring_base(cfg_ring_base), .idx(use_nxt ? nxt_idx : cur_idx),
        .word(word_sel), .addr(desc_addr)
    );

    rxr_byte_lane #(.AW(AW), .CW(BUF_CNT_W)) u_lane (
        .base(buf_q.base), .offs(offs_q), .data(in_data),
        .addr(lane_addr), .be(lane_be), .wdata(lane_data)
    );

    assign owned = (mem_rdata[7:0] & FL_OWN) != 8'h00;

    always_comb begin
        fin_flags = FL_ENP;
        if (first_q) fin_flags = fin_flags | FL_STP;
        if (ovf_q)   fin_flags = fin_flags | FL_OFLO | FL_ERR;
        if (crc_q)   fin_flags = fin_flags | FL_CRC | FL_ERR;
        if (fram_q)  fin_flags = fin_flags | FL_FRAM | FL_ERR;
    end

    always_comb begin
        state_d    = state_q;
        in_ready   = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_be     = 2'b11;
        mem_wdata  = '0;
        word_sel   = WD_FLAGS;
        use_nxt    = 1'b0;
        use_lane   = 1'b0;
        rx_event   = 1'b0;
        miss_event = 1'b0;
        advance    = 1'b0;
        byte_take  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (in_valid) begin
                    if (!in_first)      in_ready = 1'b1;   // stray byte
                    else if (in_match)  state_d  = S_FETCH_FLAGS;
                    else                state_d  = S_DROP;
                end
            end
            S_FETCH_FLAGS: begin
                mem_rd  = 1'b1;
                state_d = S_CHK_FLAGS;
            end
            S_CHK_FLAGS: begin
                if (owned) begin
                    mem_rd   = 1'b1;
                    word_sel = WD_BASE;
                    state_d  = S_GOT_BASE;
                end else begin
                    miss_event = 1'b1;
                    state_d    = S_DROP;
                end
            end
            S_FETCH_BASE: begin
                mem_rd   = 1'b1;
                word_sel = WD_BASE;
                state_d  = S_GOT_BASE;
            end
            S_GOT_BASE: begin
                mem_rd   = 1'b1;
                word_sel = WD_BLEN;
                state_d  = S_GOT_LEN;
            end
            S_GOT_LEN: state_d = S_DATA;
            S_DATA: begin
                in_ready = offs_q < buf_q.size;
                if (in_valid) begin
                    if (in_ready) begin
                        byte_take = 1'b1;
                        use_lane  = 1'b1;
                        mem_wr    = 1'b1;
                        mem_be    = lane_be;
                        mem_wdata = lane_data;
                        if (in_last) state_d = S_WB_LEN;
                    end else begin
                        state_d = S_CHAIN_FETCH;
                    end
                end
            end
            S_CHAIN_FETCH: begin
                mem_rd  = 1'b1;
                use_nxt = 1'b1;
                state_d = S_CHAIN_CHK;
            end
            S_CHAIN_CHK: state_d = owned ? S_WB_MID : S_WB_LEN;
            S_WB_MID: begin
                mem_wr    = 1'b1;
                mem_wdata = {buf_q.hi, first_q ? FL_STP : 8'h00};
                advance   = 1'b1;
                state_d   = S_FETCH_BASE;
            end
            S_WB_LEN: begin
                mem_wr    = 1'b1;
                word_sel  = WD_MLEN;
                mem_wdata = 16'(total_q);
                state_d   = S_WB_FLAGS;
            end
            S_WB_FLAGS: begin
                mem_wr    = 1'b1;
                mem_wdata = {buf_q.hi, fin_flags};
                rx_event  = 1'b1;
                advance   = 1'b1;
                state_d   = ovf_q ? S_DROP : S_IDLE;
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        mem_addr = use_lane ? lane_addr : desc_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            buf_q    <= '0;
            nxt_hi_q <= '0;
            offs_q   <= '0;
            total_q  <= '0;
            first_q  <= 1'b0;
            crc_q    <= 1'b0;
            fram_q   <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_q)
                S_CHK_FLAGS: if (owned) begin
                    buf_q.hi <= mem_rdata[15:8];
                    first_q  <= 1'b1;
                    total_q  <= '0;
                    crc_q    <= 1'b0;
                    fram_q   <= 1'b0;
                    ovf_q    <= 1'b0;
                end
                S_GOT_BASE: buf_q.base <= mem_rdata;
                S_GOT_LEN: begin
                    buf_q.size <= buf_bytes(mem_rdata[11:0]);
                    offs_q     <= '0;
                end
                S_DATA: if (byte_take) begin
                    offs_q  <= offs_q + BUF_CNT_W'(1);
                    total_q <= total_q + MSG_W'(1);
                    if (in_last) begin
                        crc_q  <= in_crc_bad;
                        fram_q <= in_frame_err;
                    end
                end
                S_CHAIN_CHK: begin
                    if (owned) nxt_hi_q <= mem_rdata[15:8];
                    else       ovf_q    <= 1'b1;
                end
                S_WB_MID: begin
                    buf_q.hi <= nxt_hi_q;
                    first_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [1:0]  mem_be,
    input logic [15:0] mem_wdata,
    input logic        rx_event,
    input logic        miss_event
);
    // R1: the cycle after reset is quiet on the memory port
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_rd && !mem_wr && !rx_event && !miss_event));

    // R2: a single-lane write only happens while a stream byte is taken
    assert_lane_write_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_be != 2'b11) |-> (in_valid && in_ready && $onehot(mem_be)));

    // R7: a miss leaves memory untouched in the next cycle and never meets a store event
    assert_miss_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        miss_event |=> !mem_wr);
    assert_miss_vs_event_R7: assert property (@(posedge clk) disable iff (rst)
        !(miss_event && rx_event));

    // R10: the release write clears OWN, carries ENP, and follows a full-word write
    assert_release_word_R10: assert property (@(posedge clk) disable iff (rst)
        rx_event |-> (mem_wr && mem_be == 2'b11 && !mem_wdata[7] && mem_wdata[0]));
    assert_len_first_R10: assert property (@(posedge clk) disable iff (rst)
        rx_event |-> $past(mem_wr && mem_be == 2'b11));

    // R9: the port never reads and writes in the same cycle
    assert_port_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (.*);

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ring_base = 16'd32;
    logic [2:0]  ring_order = 3'd2;
    logic        in_valid = 0, in_first = 0, in_last = 0, in_match = 0;
    logic        in_crc_bad = 0, in_frame_err = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, mem_rd, mem_wr, rx_event, miss_event;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_be;

    always #5 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst(rst), .cfg_ring_base(ring_base), .cfg_ring_order(ring_order),
        .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .in_match(in_match), .in_crc_bad(in_crc_bad), .in_frame_err(in_frame_err),
        .in_ready(in_ready), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_event(rx_event), .miss_event(miss_event)
    );

    // Shared memory: one-cycle read latency, byte-lane writes
    logic [15:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_wr) begin
            if (mem_be[0]) mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    int checks = 0, errors = 0;
    int rint_cnt = 0, miss_cnt = 0, wr_cnt = 0, stray = 0;

    // Per-clock observation of the port, away from the active edge
    always @(negedge clk) begin
        if (rx_event)   rint_cnt++;
        if (miss_event) miss_cnt++;
        if (mem_wr)     wr_cnt++;
        if (mem_wr && mem_addr >= 16'd1024) stray++;
    end

    // Reference model state
    int m_size [0:7];
    bit m_own  [0:7];
    int m_idx = 0;
    int seed  = 0;
    localparam int BUFB = 128;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic init_desc(input int i, input int size, input bit own);
        int a = ring_base + 4 * i;
        mem[a]     = 16'(BUFB + 64 * i);
        mem[a + 1] = {8'(8'hC0 + i), own ? 8'h80 : 8'h00};
        mem[a + 2] = 16'(-size) | 16'hF000;
        mem[a + 3] = 16'h0000;
        m_size[i]  = size;
        m_own[i]   = own;
    endtask

    task automatic send_frame(input int len, input bit match, input bit crc, input bit fram, input int s);
        @(negedge clk);
        for (int k = 0; k < len; k++) begin
            bit got;
            in_valid = 1; in_data = 8'(s + k); in_first = (k == 0); in_last = (k == len - 1);
            in_match = match; in_crc_bad = crc; in_frame_err = fram;
            forever begin
                #4;
                got = in_ready;
                @(negedge clk);
                if (got) break;
            end
        end
        in_valid = 0; in_first = 0; in_last = 0;
    endtask

    task automatic run_frame(input int len, input bit match, input bit crc, input bit fram, input string tag);
        int r0 = rint_cnt, m0 = miss_cnt, w0 = wr_cnt;
        int n = 1 << ring_order;
        int rem, k, d, nx, take, bad, a, s;
        bit first;
        logic [7:0] ef;
        seed = seed + 37;
        s = seed;
        send_frame(len, match, crc, fram, s);
        repeat (8) @(negedge clk);
        if (!match) begin
            chk({tag, " R11 no writes"}, wr_cnt - w0, 0);
            chk({tag, " R11 no miss"}, miss_cnt - m0, 0);
            return;
        end
        if (!m_own[m_idx]) begin
            chk({tag, " R7 miss pulse"}, miss_cnt - m0, 1);
            chk({tag, " R7 no writes"}, wr_cnt - w0, 0);
            return;
        end
        rem = len; k = 0; first = 1;
        forever begin
            d = m_idx;
            take = (rem < m_size[d]) ? rem : m_size[d];
            bad = 0;
            for (int j = 0; j < take; j++) begin
                logic [15:0] w = mem[BUFB + 64 * d + j / 2];
                logic [7:0]  b = (j % 2) ? w[15:8] : w[7:0];
                if (b != 8'(s + k + j)) bad++;
            end
            chk({tag, " R2 buffer bytes"}, bad, 0);
            rem -= take; k += take;
            a = ring_base + 4 * d;
            nx = (d + 1) % n;
            m_own[d] = 0;
            if (rem == 0) begin
                ef = 8'h01 | (first ? 8'h02 : 8'h00) | (crc ? 8'h48 : 8'h00) | (fram ? 8'h60 : 8'h00);
                chk({tag, " R4 final flags"}, mem[a + 1], {8'(8'hC0 + d), ef});
                chk({tag, " R4 message length"}, mem[a + 3], len);
                m_idx = nx;
                break;
            end
            if (m_own[nx]) begin
                chk({tag, " R5 chained flags"}, mem[a + 1], {8'(8'hC0 + d), first ? 8'h02 : 8'h00});
                chk({tag, " R5 no length"}, mem[a + 3], 0);
                m_idx = nx; first = 0;
            end else begin
                ef = 8'h51 | (first ? 8'h02 : 8'h00);
                chk({tag, " R8 overflow flags"}, mem[a + 1], {8'(8'hC0 + d), ef});
                chk({tag, " R8 stored length"}, mem[a + 3], k);
                m_idx = nx;
                break;
            end
        end
        chk({tag, " R10 one event"}, rint_cnt - r0, 1);
        chk({tag, " R7 no miss"}, miss_cnt - m0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", in_ready, 0);
        chk("R1 no access in reset", mem_rd | mem_wr, 0);
        chk("R1 no event in reset", rx_event | miss_event, 0);
        rst = 0;
        m_idx = 0;
        @(negedge clk);
        chk("R1 quiet after reset", mem_rd | mem_wr | rx_event | miss_event, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        for (int i = 0; i < 8; i++) begin m_size[i] = 0; m_own[i] = 0; end
        do_reset();
        // R9: four-descriptor ring placed at word 32
        for (int i = 0; i < 4; i++) init_desc(i, 64, 1);
        run_frame(20, 1, 0, 0, "R2 single");                 // descriptor 0
        init_desc(1, 8, 1); init_desc(2, 8, 1); init_desc(3, 64, 1);
        run_frame(20, 1, 1, 0, "R6 three-buffer crc");       // 1,2,3 then wrap to 0
        init_desc(0, 16, 1);
        run_frame(16, 1, 0, 0, "R3 exact fill");             // descriptor 0 only
        run_frame(10, 1, 0, 0, "R7 host owned");             // descriptor 1 still host-owned
        run_frame(14, 0, 0, 0, "R11 rejected");
        init_desc(1, 8, 1);
        run_frame(20, 1, 0, 0, "R8 overflow");               // descriptor 2 host-owned
        init_desc(2, 64, 1); init_desc(3, 64, 1); init_desc(0, 64, 1);
        run_frame(12, 1, 0, 1, "R6 framing");
        run_frame(30, 1, 0, 0, "R9 last slot");
        run_frame(5, 1, 0, 0, "R9 wrap four");
        // R9: two-descriptor ring after a fresh reset
        ring_order = 3'd1;
        do_reset();
        init_desc(0, 64, 1); init_desc(1, 64, 1);
        run_frame(6, 1, 0, 0, "R9 two slot a");
        run_frame(7, 1, 0, 0, "R9 two slot b");
        init_desc(0, 64, 1);
        run_frame(8, 1, 0, 0, "R9 wrap two");
        chk("R9 writes inside memory window", stray, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule